// File: doc/BRIEF.md
# USB Low/Full-Speed Line Codec

This block is the bit-level line coder for a low-speed or full-speed USB function. On the transmit side it takes packet bytes over a valid/ready handshake and sends a synchronisation pattern first. It then shifts every byte out least-significant bit first and inserts a forced zero after every run of six ones. The bit stream is converted to NRZI line states on a two-wire differential output. When no further byte is offered, the packet closes with a single-ended-zero period and the line returns to idle.

The receive side does the reverse on a two-wire line input. It finds the synchronisation pattern and decodes NRZI. It drops the forced zeros, assembles bytes least-significant bit first, and reports each byte, the end of packet, and any illegal run of seven ones. Each clock cycle is one bit time. Clock recovery, CRC and framing above the byte level are outside the block.

Line states are J = (dp=1, dm=0), K = (dp=0, dm=1) and single-ended zero (SE0) = (dp=0, dm=0).

Top module: `usb_line_codec`

## Requirements
- R1: After reset, and between packets, the transmit line rests in J, and tx_ready is low.
- R2: A packet starts with the 8-bit pattern 0x80 sent LSB first: seven zeros and then a one. Starting from J, this gives K J K J K J K K.
- R3: Payload bytes follow in the order they were accepted, LSB first. A 0 bit toggles the line between J and K, and a 1 bit holds it.
- R4: After six consecutive 1 bits, the transmitter inserts one 0 bit. The count of ones runs on from the pattern's final one into the first byte, and from byte to byte. A run of six at the end of the last byte is also followed by an inserted 0 before the packet ends.
- R5: A byte is taken when tx_valid and tx_ready are both high at a clock edge. tx_ready is high only in the bit time of the last bit of the current byte, and never during an inserted bit. Consecutive acceptances are therefore 8 cycles apart, plus one cycle for each inserted bit that falls before a bit of the byte just accepted.
- R6: If no byte is offered at a byte boundary, the packet ends. The line shows SE0 for two bit times and then J for one bit time, and then it idles in J.
- R7: The receiver decodes NRZI after the pattern and drops the 0 that follows six ones. It delivers each byte LSB-first assembled on rx_data with a one-cycle rx_valid pulse.
- R8: The receiver pulses rx_stuff_err when it sees seven consecutive ones, counting the pattern's final one. It then abandons the packet: it delivers no further bytes and no end-of-packet, and it waits for J before hunting again.
- R9: An SE0 during payload reception produces a one-cycle rx_eop pulse in the cycle after the SE0 is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | tx_data holds a byte to send |
| tx_ready | output | 1 | Byte is taken at this edge when tx_valid is high |
| line_dp | output | 1 | Transmit line, positive wire |
| line_dm | output | 1 | Transmit line, negative wire |
| rx_dp | input | 1 | Receive line, positive wire |
| rx_dm | input | 1 | Receive line, negative wire |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse, rx_data is new |
| rx_eop | output | 1 | One-cycle pulse, end of packet seen |
| rx_stuff_err | output | 1 | One-cycle pulse, seven consecutive ones seen |

## Verification
A correct transmitter can never produce seven ones in a row, so the receiver's error path cannot be reached by looping the transmitter back. The bench therefore switches the receive wires to a hand-built symbol stream. That stream is a valid sync pattern followed by six held line states, and then SE0 and J to let the receiver recover. Other cases are reached by choosing byte values. A first byte of 0x1F makes the ones run carry over from the pattern's final one. A last byte of 0xFC forces an inserted bit just before the end-of-packet.

// File: rtl/usb_lc_pkg.sv
package usb_lc_pkg;

    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_K   = 2'b01;
    localparam logic [1:0] LN_J   = 2'b10;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA,
        TX_TAIL,
        TX_SE0
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_SYNC,
        RX_DATA,
        RX_WAITJ
    } rx_st_e;

    function automatic logic [1:0] lvl_to_line(input logic lvl);
        return lvl ? LN_J : LN_K;
    endfunction

endpackage

// File: rtl/usb_nrzi_tx.sv
module usb_nrzi_tx
    import usb_lc_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int RUN_MAX  = 6,
    parameter int SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_dp,
    output logic              line_dm
);

    localparam int CW = $clog2(BYTE_W);
    localparam int OW = $clog2(RUN_MAX + 1);
    localparam int SW = $clog2(SE0_BITS + 1);
    localparam logic [BYTE_W-1:0] SYNC_PAT = {1'b1, {(BYTE_W-1){1'b0}}};

    typedef struct packed {
        tx_st_e            st;
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic [OW-1:0]     ones;
        logic              lvl;
        logic [1:0]        line;
        logic [SW-1:0]     se0n;
    } tx_regs_t;

    tx_regs_t q, d;
    logic     at_stuff;
    logic     last_bit;
    logic     cur_bit;
    logic     shifting;

    assign shifting = (q.st == TX_SYNC) || (q.st == TX_DATA);
    assign at_stuff = (q.ones == OW'(RUN_MAX));
    assign last_bit = (q.cnt == CW'(BYTE_W - 1));
    assign cur_bit  = q.sh[0];
    assign tx_ready = shifting && !at_stuff && last_bit;

    always_comb begin
        d = q;
        unique case (q.st)
            TX_IDLE: begin
                d.line = LN_J;
                d.lvl  = 1'b1;
                if (tx_valid) begin
                    d.st   = TX_SYNC;
                    d.sh   = SYNC_PAT;
                    d.cnt  = '0;
                    d.ones = '0;
                end
            end
            TX_SYNC, TX_DATA: begin
                if (at_stuff) begin
                    d.lvl  = ~q.lvl;
                    d.ones = '0;
                end else begin
                    d.lvl  = cur_bit ? q.lvl : ~q.lvl;
                    d.ones = cur_bit ? q.ones + OW'(1) : '0;
                    d.sh   = q.sh >> 1;
                    if (last_bit) begin
                        if (tx_valid) begin
                            d.sh  = tx_data;
                            d.cnt = '0;
                            d.st  = TX_DATA;
                        end else begin
                            d.st  = TX_TAIL;
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                d.line = lvl_to_line(d.lvl);
            end
            TX_TAIL: begin
                if (at_stuff) begin
                    d.lvl  = ~q.lvl;
                    d.ones = '0;
                    d.line = lvl_to_line(d.lvl);
                end else begin
                    d.line = LN_SE0;
                    d.se0n = SW'(1);
                    d.st   = TX_SE0;
                end
            end
            TX_SE0: begin
                if (q.se0n == SW'(SE0_BITS)) begin
                    d.line = LN_J;
                    d.lvl  = 1'b1;
                    d.st   = TX_IDLE;
                end else begin
                    d.line = LN_SE0;
                    d.se0n = q.se0n + SW'(1);
                end
            end
            default: begin
                d.st   = TX_IDLE;
                d.line = LN_J;
                d.lvl  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.line <= LN_J;
            q.lvl  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_dp = q.line[1];
    assign line_dm = q.line[0];

    // Checker: count consecutive unchanged J/K states while a packet is on the line
    logic [OW:0] run_q;
    logic [1:0]  prev_line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            prev_line_q <= LN_J;
        end else begin
            prev_line_q <= q.line;
            if ((q.st == TX_SYNC || q.st == TX_DATA || q.st == TX_TAIL) &&
                q.line != LN_SE0 && q.line == prev_line_q)
                run_q <= run_q + {{OW{1'b0}}, 1'b1};
            else
                run_q <= '0;
        end
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (OW+1)'(RUN_MAX)); // R4

    AST_EOP_ENDS_IN_J: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_SE0 && q.se0n == SW'(SE0_BITS)) |=> (line_dp && !line_dm)); // R6

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (q.st == TX_DATA && q.cnt == '0)); // R5

    AST_NO_SE0_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (line_dp || line_dm)); // R6

endmodule

// File: rtl/usb_nrzi_rx.sv
module usb_nrzi_rx
    import usb_lc_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int RUN_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_dp,
    input  logic              rx_dm,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_eop,
    output logic              rx_stuff_err
);

    localparam int CW = $clog2(BYTE_W);
    localparam int OW = $clog2(RUN_MAX + 1);

    typedef struct packed {
        rx_st_e            st;
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic [OW-1:0]     ones;
        logic              prev;
        logic [BYTE_W-1:0] data;
        logic              valid;
        logic              eop;
        logic              err;
    } rx_regs_t;

    rx_regs_t   q, d;
    logic [1:0] line;
    logic       is_se0;
    logic       bit_v;

    assign line   = {rx_dp, rx_dm};
    assign is_se0 = (line == LN_SE0);
    assign bit_v  = (rx_dp == q.prev);

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.eop   = 1'b0;
        d.err   = 1'b0;
        unique case (q.st)
            RX_HUNT: begin
                d.prev = 1'b1;
                if (line == LN_K) begin
                    d.st   = RX_SYNC;
                    d.prev = 1'b0;
                end
            end
            RX_SYNC: begin
                if (is_se0) begin
                    d.st = RX_WAITJ;
                end else begin
                    d.prev = rx_dp;
                    if (bit_v) begin
                        d.st   = RX_DATA;
                        d.ones = OW'(1);
                        d.cnt  = '0;
                    end
                end
            end
            RX_DATA: begin
                if (is_se0) begin
                    d.eop = 1'b1;
                    d.st  = RX_WAITJ;
                end else begin
                    d.prev = rx_dp;
                    if (q.ones == OW'(RUN_MAX)) begin
                        if (bit_v) begin
                            d.err = 1'b1;
                            d.st  = RX_WAITJ;
                        end else begin
                            d.ones = '0;
                        end
                    end else begin
                        d.sh   = {bit_v, q.sh[BYTE_W-1:1]};
                        d.ones = bit_v ? q.ones + OW'(1) : '0;
                        if (q.cnt == CW'(BYTE_W - 1)) begin
                            d.data  = d.sh;
                            d.valid = 1'b1;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + CW'(1);
                        end
                    end
                end
            end
            RX_WAITJ: begin
                if (line == LN_J)
                    d.st = RX_HUNT;
            end
            default: d.st = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data      = q.data;
    assign rx_valid     = q.valid;
    assign rx_eop       = q.eop;
    assign rx_stuff_err = q.err;

    AST_RX_BYTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RX_ERR_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |=> (!rx_valid && !rx_eop)); // R8

    AST_RX_EOP_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |-> ($past(rx_dp) == 1'b0 && $past(rx_dm) == 1'b0)); // R9

endmodule

// File: rtl/usb_line_codec.sv
module usb_line_codec #(
    parameter int BYTE_W   = 8,
    parameter int RUN_MAX  = 6,
    parameter int SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_dp,
    output logic              line_dm,
    input  logic              rx_dp,
    input  logic              rx_dm,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_eop,
    output logic              rx_stuff_err
);

    usb_nrzi_tx #(
        .BYTE_W   (BYTE_W),
        .RUN_MAX  (RUN_MAX),
        .SE0_BITS (SE0_BITS)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .line_dp  (line_dp),
        .line_dm  (line_dm)
    );

    usb_nrzi_rx #(
        .BYTE_W  (BYTE_W),
        .RUN_MAX (RUN_MAX)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_dp        (rx_dp),
        .rx_dm        (rx_dm),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_eop       (rx_eop),
        .rx_stuff_err (rx_stuff_err)
    );

endmodule

// File: tb/usb_line_codec_test.sv
module usb_line_codec_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       line_dp, line_dm;
    logic       inj = 1'b0;
    logic       inj_dp = 1'b1;
    logic       inj_dm = 1'b0;
    logic       rx_dp, rx_dm;
    logic [7:0] rx_data;
    logic       rx_valid, rx_eop, rx_stuff_err;

    always #10 clk = ~clk;

    assign rx_dp = inj ? inj_dp : line_dp;
    assign rx_dm = inj ? inj_dm : line_dm;

    usb_line_codec uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .line_dp      (line_dp),
        .line_dm      (line_dm),
        .rx_dp        (rx_dp),
        .rx_dm        (rx_dm),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_eop       (rx_eop),
        .rx_stuff_err (rx_stuff_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int err_seen = 0;

    int    sym_q[$];
    string tag_q[$];
    bit    end_q[$];
    int    rx_q[$];
    int    gap_q[$];
    bit    m_lvl;
    int    m_ones;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // line symbols: 2 = J, 1 = K, 0 = SE0
    function automatic void emit(input bit b, input string tag);
        if (!b) m_lvl = ~m_lvl;
        sym_q.push_back(m_lvl ? 2 : 1);
        tag_q.push_back(tag);
        end_q.push_back(1'b0);
        m_ones = b ? m_ones + 1 : 0;
    endfunction

    function automatic void push_line(input int s, input string tag, input bit e);
        sym_q.push_back(s);
        tag_q.push_back(tag);
        end_q.push_back(e);
    endfunction

    function automatic void model_packet(input logic [7:0] p[$]);
        int st;
        m_lvl  = 1'b1;
        m_ones = 0;
        for (int i = 0; i < 8; i++) emit(i == 7, "R2");
        for (int k = 0; k < p.size(); k++) begin
            st = 0;
            for (int i = 0; i < 8; i++) begin
                if (m_ones == 6) begin
                    emit(1'b0, "R4");
                    st++;
                end
                emit(p[k][i], "R3");
            end
            if (k < p.size() - 1) gap_q.push_back(8 + st);
            rx_q.push_back(int'(p[k]));
        end
        if (m_ones == 6) emit(1'b0, "R4");
        push_line(0, "R6", 1'b0);
        push_line(0, "R6", 1'b0);
        push_line(2, "R6", 1'b1);
        rx_q.push_back(-1);
    endfunction

    task automatic wait_drain();
        int n;
        n = 0;
        while ((sym_q.size() > 0 || rx_q.size() > 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(sym_q.size() == 0, "R6", "line symbols left", sym_q.size(), 0);
        check(rx_q.size() == 0, "R7", "rx items left", rx_q.size(), 0);
        repeat (3) @(negedge clk);
        check({line_dp, line_dm} == 2'b10, "R1", "idle line between packets",
              {line_dp, line_dm}, 2);
    endtask

    task automatic send_packet(input logic [7:0] p[$]);
        int last;
        last = 0;
        model_packet(p);
        for (int k = 0; k < p.size(); k++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_data  = p[k];
            while (!tx_ready) @(negedge clk);
            if (k > 0) begin
                int e;
                e = gap_q.pop_front();
                check((cyc - last) == e, "R5", "byte acceptance spacing", cyc - last, e);
            end
            last = cyc;
        end
        @(negedge clk);
        tx_valid = 1'b0;
        tx_data  = '0;
        wait_drain();
    endtask

    task automatic drive_sym(input logic [1:0] s);
        @(negedge clk);
        inj_dp = s[1];
        inj_dm = s[0];
    endtask

    // scoreboard monitor
    initial begin
        bit active;
        int e;
        string t;
        bit en;
        logic [1:0] s;
        active = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                s = {line_dp, line_dm};
                if (!active && s != 2'b10) begin
                    if (sym_q.size() > 0) active = 1'b1;
                    else check(1'b0, "R1", "unexpected line activity", s, 2);
                end
                if (active) begin
                    e  = sym_q.pop_front();
                    t  = tag_q.pop_front();
                    en = end_q.pop_front();
                    check(int'(s) == e, t, "line symbol", s, e);
                    if (en) active = 1'b0;
                end
                if (rx_valid) begin
                    if (rx_q.size() == 0 || rx_q[0] < 0)
                        check(1'b0, "R7", "unexpected rx byte", rx_data, -1);
                    else begin
                        e = rx_q.pop_front();
                        check(int'(rx_data) == e, "R7", "rx byte", rx_data, e);
                    end
                end
                if (rx_eop) begin
                    if (rx_q.size() == 0 || rx_q[0] >= 0)
                        check(1'b0, "R9", "unexpected rx end", 1, 0);
                    else begin
                        e = rx_q.pop_front();
                        check(1'b1, "R9", "rx end of packet", 1, 1);
                    end
                end
                if (rx_stuff_err) err_seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pk[$];
        repeat (3) @(negedge clk);
        check({line_dp, line_dm} == 2'b10, "R1", "line in reset", {line_dp, line_dm}, 2);
        check(tx_ready == 1'b0, "R1", "tx_ready in reset", tx_ready, 0);
        check(rx_valid == 1'b0, "R7", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({line_dp, line_dm} == 2'b10, "R1", "line idle after reset",
              {line_dp, line_dm}, 2);

        pk = '{8'hC3, 8'h00, 8'h55};
        send_packet(pk);               // R3 mixed patterns
        pk = '{8'hFF, 8'hFF};
        send_packet(pk);               // R4 stuffing inside and across bytes
        pk = '{8'h1F, 8'h0F};
        send_packet(pk);               // R4 run carried from the sync's final one
        pk = '{8'h5A, 8'hFC};
        send_packet(pk);               // R4 stuffed bit just before end of packet
        pk = '{8'h7E, 8'hFF, 8'h01, 8'h80};
        send_packet(pk);               // R5 spacing with stuffing

        // R8: seven consecutive ones injected on the receive wires
        inj = 1'b1;
        repeat (3) drive_sym(2'b10);
        drive_sym(2'b01); drive_sym(2'b10); drive_sym(2'b01); drive_sym(2'b10);
        drive_sym(2'b01); drive_sym(2'b10); drive_sym(2'b01); drive_sym(2'b01);
        repeat (6) drive_sym(2'b01);
        drive_sym(2'b00);
        drive_sym(2'b00);
        drive_sym(2'b10);
        drive_sym(2'b10);
        @(negedge clk);
        check(err_seen == 1, "R8", "stuff error pulses", err_seen, 1);
        check(rx_q.size() == 0, "R8", "no data expected after error", rx_q.size(), 0);
        inj = 1'b0;
        repeat (2) @(negedge clk);

        pk = '{8'hA5};
        send_packet(pk);               // R8 receiver recovers after error
        check(err_seen == 1, "R8", "no error on clean traffic", err_seen, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule